// File: doc/BRIEF.md
# Gated Control/Status Register Bank

This block is a bank of 16-bit control and status registers inside a network controller. Software reaches it through a simple indexed port: an index, a write strobe with write data, and a read strobe. Read data comes back one cycle later with a valid flag. The bank holds a suspend bit and a set of wake-on-packet bits: a mode bit, a force-enable bit, an interrupt unmask and a received-packet flag. It also holds a read-only copy of the encoded transmit and receive ring-length codes, and a 64-bit multicast filter spread over four consecutive registers.

Event inputs clear or set bits. These are a wake-packet received pulse, the STOP status level, the hardware reset pin, a strobe that marks a read of the reset register, and a sleep pin. The outputs are the wake-up mode, a sleep request, a registered interrupt request and the full filter vector. The ring-length and filter registers are gated. They can be reached only while STOP is asserted or the suspend bit is set. At any other time a read of them returns zero and a write to them is dropped.

Top module: `nic_gated_csr_bank`

## Requirements
- R1: After the synchronous reset `rst`, all wake bits, the ring-length copy, the filter vector, `irq`, `rd_valid` and `rd_data` are zero.
- R2: A read strobe returns data on `rd_data` with `rd_valid` high in the next cycle. The wake register sits at index 5 and is always accessible. Its layout is bit0 suspend, bit1 mode, bit2 force-enable, bit3 interrupt unmask and bit4 packet flag, and its upper bits read zero. An index with no register behind it reads zero.
- R3: The suspend bit is cleared by `rst_pin`, by `rst_reg_rd`, or by `stop_in` being high in a cycle.
- R4: The mode and force-enable bits are cleared only by `rst_pin` or `rst_reg_rd`. A STOP level leaves them unchanged.
- R5: The interrupt unmask bit is cleared by `rst_pin`, by `rst_reg_rd`, or by `stop_in`.
- R6: `pkt_rx` sets the packet flag. Writing 1 to bit4 clears the flag and writing 0 to bit4 leaves it alone. If a set and a write-one clear fall in the same cycle, the set wins. A reset source in the same cycle beats the set.
- R7: `irq` is the AND of the packet flag and the unmask bit, delayed by one register.
- R8: `wake_mode` is mode AND (force-enable OR `sleep_pin`). `sleep_req` is `sleep_pin` AND NOT mode. This means that while the mode bit is set, the sleep pin acts as a wake enable instead of a sleep request.
- R9: The ring-length register at index 6 reads as {transmit code in bits 15:12, receive code in bits 11:8, zeros in bits 7:0}. It loads from `init_tlen`/`init_rlen` on `init_load`, and writes to it have no effect.
- R10: The filter registers sit at indices 8 to 11. Index 8 holds `filter_vec[15:0]` and index 11 holds `filter_vec[63:48]`. Each is readable and writable.
- R11: The ring-length and filter registers are open only while `stop_in` or the suspend bit is 1. When they are closed, reads of them return zero and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_idx | input | 4 | Register index |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 16 | Write data |
| acc_rd | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| stop_in | input | 1 | Controller STOP level |
| rst_pin | input | 1 | Hardware reset pin, clears control bits |
| rst_reg_rd | input | 1 | Strobe: reset register was read |
| sleep_pin | input | 1 | Sleep request or wake enable, depending on the mode bit |
| pkt_rx | input | 1 | Wake packet received pulse |
| init_load | input | 1 | Load the ring-length codes |
| init_tlen | input | 4 | Encoded transmit ring length |
| init_rlen | input | 4 | Encoded receive ring length |
| wake_mode | output | 1 | Wake-packet mode active |
| sleep_req | output | 1 | Sleep request |
| irq | output | 1 | Registered wake interrupt |
| filter_vec | output | 64 | Multicast filter vector |

## Verification
Several rules are checked by the assertions on every cycle. Each clear source empties the suspend and unmask bits. STOP leaves the mode and force bits in place. A received packet always sets the flag unless a reset source arrives with it. A masked flag never raises `irq`, and `wake_mode` stays low while the mode bit is clear. The filter holds its value and the ring copy holds between loads whenever the gate is closed. Other behaviour can only be shown by the bench's scenarios. This includes the register layout and the filter word order as software sees them, and the write-one-clear against same-cycle set priority. It also includes the exact sleep-pin reinterpretation, and the proof that dropped writes really left the gated registers unchanged once the gate reopens.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
    localparam int DATA_W = 16;
    localparam int CODE_W = 4;

    typedef logic [DATA_W-1:0] word_t;

    // bit0 suspend .. bit4 packet flag (first member is the MSB)
    typedef struct packed {
        logic intr;
        logic ien;
        logic force_on;
        logic mode;
        logic spnd;
    } wake_bits_t;

    localparam int WAKE_W = $bits(wake_bits_t);

    typedef struct packed {
        logic rst_pin;
        logic rst_reg_rd;
        logic stop;
    } clr_src_t;

    typedef struct packed {
        logic [CODE_W-1:0] tlen;
        logic [CODE_W-1:0] rlen;
    } ring_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_WAKE,
        SEL_RING,
        SEL_FLT
    } sel_e;

    function automatic word_t pack_wake(wake_bits_t w);
        return {{(DATA_W-WAKE_W){1'b0}}, w};
    endfunction

    function automatic word_t pack_ring(ring_t r);
        return {r, {(DATA_W-$bits(ring_t)){1'b0}}};
    endfunction
endpackage

// File: rtl/gcsr_decode.sv
module gcsr_decode
    import gcsr_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int WAKE_IDX  = 5,
    parameter int RING_IDX  = 6,
    parameter int FLT_BASE  = 8,
    parameter int FLT_WORDS = 4,
    localparam int FSEL_W   = (FLT_WORDS > 1) ? $clog2(FLT_WORDS) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output sel_e              sel,
    output logic [FSEL_W-1:0] fsel
);
    int unsigned idx_i;

    always_comb begin
        idx_i = 32'(idx);
        sel   = SEL_NONE;
        fsel  = '0;
        if (idx_i == WAKE_IDX) begin
            sel = SEL_WAKE;
        end else if (idx_i == RING_IDX) begin
            sel = SEL_RING;
        end else if (idx_i >= FLT_BASE && idx_i < FLT_BASE + FLT_WORDS) begin
            sel  = SEL_FLT;
            fsel = FSEL_W'(idx_i - FLT_BASE);
        end
    end
endmodule

// File: rtl/gcsr_wake_ctl.sv
module gcsr_wake_ctl
    import gcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  wake_bits_t wr_bits,
    input  clr_src_t   clr,
    input  logic       pkt_rx,
    input  logic       sleep_pin,
    output wake_bits_t bits,
    output logic       wake_mode,
    output logic       sleep_req,
    output logic       irq
);
    wake_bits_t nxt;
    logic       hard_clr;

    assign hard_clr = clr.rst_pin | clr.rst_reg_rd;

    always_comb begin
        nxt = bits;
        if (wr_en) begin
            nxt.spnd     = wr_bits.spnd;
            nxt.mode     = wr_bits.mode;
            nxt.force_on = wr_bits.force_on;
            nxt.ien      = wr_bits.ien;
            if (wr_bits.intr) nxt.intr = 1'b0;
        end
        if (pkt_rx) nxt.intr = 1'b1;
        if (clr.stop) begin
            nxt.spnd = 1'b0;
            nxt.ien  = 1'b0;
        end
        if (hard_clr) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
            irq  <= 1'b0;
        end else begin
            bits <= nxt;
            irq  <= bits.intr & bits.ien;
        end
    end

    assign wake_mode = bits.mode & (bits.force_on | sleep_pin);
    assign sleep_req = sleep_pin & ~bits.mode;

    a_r3_spnd_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr.stop | clr.rst_pin | clr.rst_reg_rd) |=> !bits.spnd);

    a_r4_stop_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (clr.stop && !hard_clr && !wr_en) |=>
            (bits.mode == $past(bits.mode) && bits.force_on == $past(bits.force_on)));

    a_r5_ien_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr.stop | hard_clr) |=> !bits.ien);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (pkt_rx && !hard_clr) |=> bits.intr);

    a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
        !bits.ien |=> !irq);

    a_r8_mode_prereq: assert property (@(posedge clk) disable iff (rst)
        !bits.mode |-> !wake_mode);
endmodule

// File: rtl/gcsr_ring_hold.sv
module gcsr_ring_hold
    import gcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] tlen,
    input  logic [CODE_W-1:0] rlen,
    output ring_t             ring
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ring <= '0;
        end else if (load) begin
            ring.tlen <= tlen;
            ring.rlen <= rlen;
        end
    end

    a_r9_ring_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ring));
endmodule

// File: rtl/gcsr_filter_bank.sv
module gcsr_filter_bank
    import gcsr_pkg::*;
#(
    parameter int FLT_WORDS = 4,
    localparam int FSEL_W   = (FLT_WORDS > 1) ? $clog2(FLT_WORDS) : 1,
    localparam int FLT_W    = FLT_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FSEL_W-1:0] fsel,
    input  word_t             wdata,
    output word_t             rd_word,
    output logic [FLT_W-1:0]  flt_vec
);
    word_t words [FLT_WORDS];

    for (genvar gi = 0; gi < FLT_WORDS; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[gi] <= '0;
            end else if (wr_en && (32'(fsel) == gi)) begin
                words[gi] <= wdata;
            end
        end
        assign flt_vec[gi*DATA_W +: DATA_W] = words[gi];
    end

    assign rd_word = words[fsel];
endmodule

// File: rtl/nic_gated_csr_bank.sv
module nic_gated_csr_bank
    import gcsr_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int WAKE_IDX  = 5,
    parameter int RING_IDX  = 6,
    parameter int FLT_BASE  = 8,
    parameter int FLT_WORDS = 4,
    localparam int FSEL_W   = (FLT_WORDS > 1) ? $clog2(FLT_WORDS) : 1,
    localparam int FLT_W    = FLT_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              stop_in,
    input  logic              rst_pin,
    input  logic              rst_reg_rd,
    input  logic              sleep_pin,
    input  logic              pkt_rx,
    input  logic              init_load,
    input  logic [CODE_W-1:0] init_tlen,
    input  logic [CODE_W-1:0] init_rlen,
    output logic              wake_mode,
    output logic              sleep_req,
    output logic              irq,
    output logic [FLT_W-1:0]  filter_vec
);
    sel_e              sel;
    logic [FSEL_W-1:0] fsel;
    wake_bits_t        wbits;
    ring_t             ring;
    word_t             flt_word;
    word_t             rd_next;
    clr_src_t          clr;
    logic              gate_open;

    assign clr       = '{rst_pin: rst_pin, rst_reg_rd: rst_reg_rd, stop: stop_in};
    assign gate_open = stop_in | wbits.spnd;

    gcsr_decode #(
        .IDX_W(IDX_W), .WAKE_IDX(WAKE_IDX), .RING_IDX(RING_IDX),
        .FLT_BASE(FLT_BASE), .FLT_WORDS(FLT_WORDS)
    ) u_decode (
        .idx (acc_idx),
        .sel (sel),
        .fsel(fsel)
    );

    gcsr_wake_ctl u_wake (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (acc_wr && sel == SEL_WAKE),
        .wr_bits  (wake_bits_t'(acc_wdata[WAKE_W-1:0])),
        .clr      (clr),
        .pkt_rx   (pkt_rx),
        .sleep_pin(sleep_pin),
        .bits     (wbits),
        .wake_mode(wake_mode),
        .sleep_req(sleep_req),
        .irq      (irq)
    );

    gcsr_ring_hold u_ring (
        .clk (clk),
        .rst (rst),
        .load(init_load),
        .tlen(init_tlen),
        .rlen(init_rlen),
        .ring(ring)
    );

    gcsr_filter_bank #(.FLT_WORDS(FLT_WORDS)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (acc_wr && sel == SEL_FLT && gate_open),
        .fsel   (fsel),
        .wdata  (acc_wdata),
        .rd_word(flt_word),
        .flt_vec(filter_vec)
    );

    always_comb begin
        unique case (sel)
            SEL_WAKE: rd_next = pack_wake(wbits);
            SEL_RING: rd_next = gate_open ? pack_ring(ring) : '0;
            SEL_FLT:  rd_next = gate_open ? flt_word : '0;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= acc_rd;
            if (acc_rd) rd_data <= rd_next;
        end
    end

    a_r2_rd_valid: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rd_valid);

    a_r11_closed_read_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && !gate_open && (sel == SEL_RING || sel == SEL_FLT)) |=> rd_data == '0);

    a_r11_closed_no_write: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> $stable(filter_vec));
endmodule

// File: tb/test_nic_gated_csr_bank.sv
module test_nic_gated_csr_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  acc_idx = '0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic        acc_rd = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        stop_in = 1'b0;
    logic        rst_pin = 1'b0;
    logic        rst_reg_rd = 1'b0;
    logic        sleep_pin = 1'b0;
    logic        pkt_rx = 1'b0;
    logic        init_load = 1'b0;
    logic [3:0]  init_tlen = '0;
    logic [3:0]  init_rlen = '0;
    logic        wake_mode;
    logic        sleep_req;
    logic        irq;
    logic [63:0] filter_vec;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    nic_gated_csr_bank i_nic_gated_csr_bank (
        .clk(clk), .rst(rst), .acc_idx(acc_idx), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rd(acc_rd), .rd_data(rd_data),
        .rd_valid(rd_valid), .stop_in(stop_in), .rst_pin(rst_pin),
        .rst_reg_rd(rst_reg_rd), .sleep_pin(sleep_pin), .pkt_rx(pkt_rx),
        .init_load(init_load), .init_tlen(init_tlen), .init_rlen(init_rlen),
        .wake_mode(wake_mode), .sleep_req(sleep_req), .irq(irq),
        .filter_vec(filter_vec)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares every returned read against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected read data", 64'(rd_data), 64'hx);
            end else begin
                chk(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic do_rd(logic [3:0] idx, logic [15:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_idx = idx;
        acc_rd  = 1'b1;
        @(negedge clk);
        acc_rd  = 1'b0;
    endtask

    task automatic do_wr(logic [3:0] idx, logic [15:0] data);
        @(negedge clk);
        acc_idx   = idx;
        acc_wdata = data;
        acc_wr    = 1'b1;
        @(negedge clk);
        acc_wr    = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 filter", filter_vec, 0);
        chk("R1 rd_valid", 64'(rd_valid), 0);
        chk("R1 wake_mode", 64'(wake_mode), 0);
        do_rd(4'd5, 16'h0000, "R1 wake reg after reset");
        do_rd(4'd3, 16'h0000, "R2 unmapped index");

        // R11 gate closed: write dropped
        do_wr(4'd8, 16'hAAAA);
        do_rd(4'd8, 16'h0000, "R11 closed filter read");
        stop_in = 1'b1;
        do_rd(4'd8, 16'h0000, "R11 closed write ignored");
        chk("R11 filter untouched", filter_vec, 0);

        // R10 filter order
        do_wr(4'd8, 16'h1111);
        do_wr(4'd9, 16'h2222);
        do_wr(4'd10, 16'h3333);
        do_wr(4'd11, 16'h4444);
        do_rd(4'd8, 16'h1111, "R10 word 8");
        do_rd(4'd11, 16'h4444, "R10 word 11");
        @(negedge clk);
        chk("R10 filter vector", filter_vec, 64'h4444_3333_2222_1111);

        // R9 ring copy
        init_tlen = 4'h5;
        init_rlen = 4'h9;
        pulse(init_load);
        do_wr(4'd6, 16'hFFFF);
        do_rd(4'd6, 16'h5900, "R9 ring layout, write ignored");

        // R11 suspend opens the gate
        @(negedge clk);
        stop_in = 1'b0;
        do_rd(4'd6, 16'h0000, "R11 closed ring read");
        do_wr(4'd5, 16'h0001);
        do_rd(4'd6, 16'h5900, "R11 suspend opens ring");
        do_rd(4'd9, 16'h2222, "R11 suspend opens filter");
        do_rd(4'd5, 16'h0001, "R2 suspend bit position");

        // R3 suspend clear sources
        pulse(rst_reg_rd);
        do_rd(4'd5, 16'h0000, "R3 cleared by reset-register read");
        do_wr(4'd5, 16'h0001);
        pulse(rst_pin);
        do_rd(4'd5, 16'h0000, "R3 cleared by reset pin");
        do_wr(4'd5, 16'h0001);
        pulse(stop_in);
        do_rd(4'd5, 16'h0000, "R3 cleared by STOP");

        // R4 / R5
        do_wr(4'd5, 16'h000E);
        do_rd(4'd5, 16'h000E, "R4 mode/force/unmask written");
        pulse(stop_in);
        do_rd(4'd5, 16'h0006, "R4 R5 STOP clears only unmask");
        pulse(rst_reg_rd);
        do_rd(4'd5, 16'h0000, "R4 reset-register read clears mode/force");

        // R8 sleep pin meaning
        do_wr(4'd5, 16'h0002);
        @(negedge clk);
        chk("R8 mode, sleep low: wake", 64'(wake_mode), 0);
        chk("R8 mode, sleep low: sleep", 64'(sleep_req), 0);
        sleep_pin = 1'b1;
        @(negedge clk);
        chk("R8 mode, sleep high: wake", 64'(wake_mode), 1);
        chk("R8 mode, sleep high: sleep", 64'(sleep_req), 0);
        do_wr(4'd5, 16'h0000);
        @(negedge clk);
        chk("R8 no mode: sleep request", 64'(sleep_req), 1);
        chk("R8 no mode: wake", 64'(wake_mode), 0);
        sleep_pin = 1'b0;
        do_wr(4'd5, 16'h0004);
        @(negedge clk);
        chk("R8 force without mode", 64'(wake_mode), 0);
        do_wr(4'd5, 16'h0006);
        @(negedge clk);
        chk("R8 force with mode", 64'(wake_mode), 1);

        // R6 / R7
        do_wr(4'd5, 16'h0008);
        pulse(pkt_rx);
        @(negedge clk);
        chk("R7 irq raised", 64'(irq), 1);
        do_rd(4'd5, 16'h0018, "R6 flag set by packet");
        do_wr(4'd5, 16'h0008);
        do_rd(4'd5, 16'h0018, "R6 write zero keeps flag");
        do_wr(4'd5, 16'h0018);
        @(negedge clk);
        chk("R7 irq dropped", 64'(irq), 0);
        do_rd(4'd5, 16'h0008, "R6 write one clears flag");
        @(negedge clk);
        acc_idx = 4'd5; acc_wdata = 16'h0018; acc_wr = 1'b1; pkt_rx = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; pkt_rx = 1'b0;
        do_rd(4'd5, 16'h0018, "R6 set beats clear");
        @(negedge clk);
        pkt_rx = 1'b1; rst_pin = 1'b1;
        @(negedge clk);
        pkt_rx = 1'b0; rst_pin = 1'b0;
        do_rd(4'd5, 16'h0000, "R6 reset pin beats set");
        pulse(pkt_rx);
        @(negedge clk);
        chk("R7 masked flag no irq", 64'(irq), 0);
        do_rd(4'd5, 16'h0010, "R6 flag without unmask");

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 64'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule